// File: doc/BRIEF.md
# Dual-Image Boot Selector

This block decides which of two stored firmware or bitstream images a system starts from. After a start pulse it fetches a pointer word from a fixed address in a flash-like memory. It decodes a single bit of that word to pick a preferred image. It then reads the header word at the base of that image. If the header shows a usable image, the block presents the image base address and fires a one-cycle launch strobe. It then waits for the launched image to confirm that it came up.

There are two ways an attempt can fail. The header can show no usable image, or the launched image can stay silent for a whole watchdog window. In either case the block turns to the other image. Each image gets one attempt per start. When both attempts fail, the block parks in a failed state and reports a dedicated status code.

Memory reads use a plain request/ready port. Because flash can only clear bits, a flipped pointer is made by clearing one bit. Every pointer value, including a half-written one, decodes to exactly one image.

Top module: `boot_image_selector`

## Requirements
- R1: After reset, status is 0 (idle), and both the launch strobe and the memory read request are low.
- R2: A start pulse accepted while idle, booted or failed first issues a read at address PTR_ADDR. Every read keeps its request high and its address stable until a cycle with memory ready high.
- R3: Bit SEL_BIT of the pointer word chooses the first image tried. A value of 1 (erased) selects image A at BASE_A, and 0 selects image B at BASE_B. All other pointer bits have no effect.
- R4: The header word is read at the base address of the image under trial. The image is usable only when header bit VALID_BIT is 0. An all-ones (erased) header is therefore unusable, and the block moves on to the other image without launching.
- R5: A usable image is launched by a launch strobe that is high for exactly one cycle. While it is high, imageBase equals that image's base address.
- R6: A bootDone pulse in any of the WDOG_CYCLES cycles that follow the launch cycle ends the sequence with status 4 (booted from A) or 5 (booted from B). That status is held until the next start.
- R7: If no bootDone arrives within those WDOG_CYCLES cycles, the block reads the other image's header and tries that image.
- R8: Each image is tried at most once per start. When both fail, status becomes 7 and stays there until a new start, with at most two launches in total.
- R9: Status reads 1 while the pointer or a header is being read. It reads 2 from the launch cycle through the watchdog window.
- R10: bootDone outside the watchdog window, and start while a sequence is in progress, have no effect on the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a selection sequence |
| memRd | output | 1 | Read request, held until memReady |
| memAddr | output | ADDR_W | Read address |
| memData | input | DATA_W | Read data, valid with memReady |
| memReady | input | 1 | Read completes in this cycle |
| bootDone | input | 1 | Launched image confirms it is running |
| imageBase | output | ADDR_W | Base address of the image under trial |
| launch | output | 1 | One-cycle strobe to start the image |
| status | output | 3 | 0 idle, 1 searching, 2 waiting, 4 booted A, 5 booted B, 7 failed |

## Verification
The bench builds the block with a 16-bit address and a watchdog of only 8 cycles. With so short a window, confirmations exactly at the last accepted cycle and one cycle late can both be placed precisely. The selector bit is moved to bit 3 and the header valid bit to bit 5. Random pointer words therefore exercise the claim that only one pointer bit matters, and random headers mix valid, invalid and erased contents. Memory ready latency is random, so every read is seen both completing at once and held for several cycles.

// File: rtl/boot_sel_pkg.sv
package boot_sel_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_PTR,
    ST_RD_HDR,
    ST_LAUNCH,
    ST_WAIT,
    ST_FALLBACK,
    ST_DONE,
    ST_FAILED
  } selState_t;

  localparam logic [2:0] STAT_IDLE    = 3'd0;
  localparam logic [2:0] STAT_SEARCH  = 3'd1;
  localparam logic [2:0] STAT_WAITING = 3'd2;
  localparam logic [2:0] STAT_BOOT_A  = 3'd4;
  localparam logic [2:0] STAT_BOOT_B  = 3'd5;
  localparam logic [2:0] STAT_FAILED  = 3'd7;

  typedef struct packed {
    logic addrPtr;
    logic selFromPtr;
    logic flipSel;
    logic clrWdog;
    logic runWdog;
  } dpCtl_t;

endpackage

// File: rtl/boot_sel_datapath.sv
module boot_sel_datapath
  import boot_sel_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int DATA_W      = 32,
  parameter logic [ADDR_W-1:0] PTR_ADDR = '0,
  parameter logic [ADDR_W-1:0] BASE_A   = 24'h010000,
  parameter logic [ADDR_W-1:0] BASE_B   = 24'h080000,
  parameter int SEL_BIT     = 0,
  parameter int VALID_BIT   = 31,
  parameter int WDOG_CYCLES = 1000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [DATA_W-1:0] memData,
  output logic              curSel,
  output logic              hdrGood,
  output logic              wdogExpired,
  output logic [ADDR_W-1:0] imageBase,
  output logic [ADDR_W-1:0] memAddr
);

  localparam int CNT_W = (WDOG_CYCLES > 2) ? $clog2(WDOG_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WDOG_CYCLES - 1);

  logic [CNT_W-1:0] wdogCnt;
  logic unusedData;

  assign unusedData = ^memData;

  // image select: 0 = A, 1 = B; pointer bit erased (1) means A
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curSel <= 1'b0;
    end else if (ctl.selFromPtr) begin
      curSel <= ~memData[SEL_BIT];
    end else if (ctl.flipSel) begin
      curSel <= ~curSel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clrWdog) begin
      wdogCnt <= '0;
    end else if (ctl.runWdog && wdogCnt != CNT_LAST) begin
      wdogCnt <= wdogCnt + 1'b1;
    end
  end

  assign hdrGood     = ~memData[VALID_BIT];
  assign wdogExpired = ctl.runWdog && (wdogCnt == CNT_LAST);
  assign imageBase   = curSel ? BASE_B : BASE_A;
  assign memAddr     = ctl.addrPtr ? PTR_ADDR : imageBase;

  AST_SEL_FLIPS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.flipSel && !ctl.selFromPtr |=> curSel != $past(curSel)) else $error("flip"); // R7

  AST_WDOG_FROM_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clrWdog |=> wdogCnt == '0) else $error("wdog clear"); // R6

endmodule

// File: rtl/boot_sel_ctrl.sv
module boot_sel_ctrl
  import boot_sel_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       memReady,
  input  logic       bootDone,
  input  logic       curSel,
  input  logic       hdrGood,
  input  logic       wdogExpired,
  output dpCtl_t     ctl,
  output logic       memRd,
  output logic       launch,
  output logic [2:0] status
);

  selState_t state, nextState;
  logic secondTry;

  always_comb begin
    nextState = state;
    ctl       = '0;
    memRd     = 1'b0;
    launch    = 1'b0;
    case (state)
      ST_IDLE, ST_DONE, ST_FAILED: begin
        if (start) nextState = ST_RD_PTR;
      end
      ST_RD_PTR: begin
        memRd       = 1'b1;
        ctl.addrPtr = 1'b1;
        if (memReady) begin
          ctl.selFromPtr = 1'b1;
          nextState      = ST_RD_HDR;
        end
      end
      ST_RD_HDR: begin
        memRd = 1'b1;
        if (memReady) nextState = hdrGood ? ST_LAUNCH : ST_FALLBACK;
      end
      ST_LAUNCH: begin
        launch      = 1'b1;
        ctl.clrWdog = 1'b1;
        nextState   = ST_WAIT;
      end
      ST_WAIT: begin
        ctl.runWdog = 1'b1;
        if (bootDone) nextState = ST_DONE;
        else if (wdogExpired) nextState = ST_FALLBACK;
      end
      ST_FALLBACK: begin
        if (secondTry) begin
          nextState = ST_FAILED;
        end else begin
          ctl.flipSel = 1'b1;
          nextState   = ST_RD_HDR;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      secondTry <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_RD_PTR) secondTry <= 1'b0;
      else if (ctl.flipSel) secondTry <= 1'b1;
    end
  end

  always_comb begin
    case (state)
      ST_IDLE:             status = STAT_IDLE;
      ST_LAUNCH, ST_WAIT:  status = STAT_WAITING;
      ST_DONE:             status = curSel ? STAT_BOOT_B : STAT_BOOT_A;
      ST_FAILED:           status = STAT_FAILED;
      default:             status = STAT_SEARCH;
    endcase
  end

  AST_LAUNCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    launch |=> !launch) else $error("launch width"); // R5

  AST_TIMEOUT_FALLS_BACK: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_WAIT && wdogExpired && !bootDone |=> state == ST_FALLBACK) else $error("timeout"); // R7

  AST_SECOND_FAIL_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_FALLBACK && secondTry |=> state == ST_FAILED) else $error("second fail"); // R8

  AST_FAILED_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_FAILED && !start |=> state == ST_FAILED) else $error("failed sticky"); // R8

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_DONE && !start |=> $stable(status)) else $error("done sticky"); // R6

endmodule

// File: rtl/boot_image_selector.sv
module boot_image_selector
  import boot_sel_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int DATA_W      = 32,
  parameter logic [ADDR_W-1:0] PTR_ADDR = '0,
  parameter logic [ADDR_W-1:0] BASE_A   = 24'h010000,
  parameter logic [ADDR_W-1:0] BASE_B   = 24'h080000,
  parameter int SEL_BIT     = 0,
  parameter int VALID_BIT   = 31,
  parameter int WDOG_CYCLES = 1000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              memRd,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memData,
  input  logic              memReady,
  input  logic              bootDone,
  output logic [ADDR_W-1:0] imageBase,
  output logic              launch,
  output logic [2:0]        status
);

  dpCtl_t ctl;
  logic   curSel;
  logic   hdrGood;
  logic   wdogExpired;

  boot_sel_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .memReady    (memReady),
    .bootDone    (bootDone),
    .curSel      (curSel),
    .hdrGood     (hdrGood),
    .wdogExpired (wdogExpired),
    .ctl         (ctl),
    .memRd       (memRd),
    .launch      (launch),
    .status      (status)
  );

  boot_sel_datapath #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .PTR_ADDR    (PTR_ADDR),
    .BASE_A      (BASE_A),
    .BASE_B      (BASE_B),
    .SEL_BIT     (SEL_BIT),
    .VALID_BIT   (VALID_BIT),
    .WDOG_CYCLES (WDOG_CYCLES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .memData     (memData),
    .curSel      (curSel),
    .hdrGood     (hdrGood),
    .wdogExpired (wdogExpired),
    .imageBase   (imageBase),
    .memAddr     (memAddr)
  );

  AST_READ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    memRd && !memReady |=> memRd && $stable(memAddr)) else $error("read hold"); // R2

  AST_LAUNCH_BASE: assert property (@(posedge clk) disable iff (!rstN)
    launch |-> (imageBase == BASE_A || imageBase == BASE_B)) else $error("base"); // R5

endmodule

// File: tb/boot_image_selector_bench.sv
module boot_image_selector_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam logic [AW-1:0] P_ADDR = 16'h0000;
  localparam logic [AW-1:0] B_A = 16'h0100;
  localparam logic [AW-1:0] B_B = 16'h8000;
  localparam int SBIT = 3;
  localparam int VBIT = 5;
  localparam int WD = 8;

  logic clk = 1'b0, rstN = 1'b0, startTask = 1'b0, startExtra = 1'b0;
  logic memRd, memReady = 1'b0, bootDone = 1'b0, launch;
  logic [AW-1:0] memAddr, imageBase;
  logic [DW-1:0] memData = '0;
  logic [2:0] status;

  int checks = 0, fails = 0;

  // memory image and responder setup
  logic [DW-1:0] ptrWord, hdrA, hdrB;
  int dlyA, dlyB, lat = 0;
  bit startOnLaunch = 0;

  // monitor results
  int launches, bdCnt, bdActive, bdDly, holdErr, readIdx;
  logic [AW-1:0] firstLaunchBase, firstRdAddr, firstHdrAddr;
  bit sawSearch, sawWait;
  logic prevRd, prevReady;
  logic [AW-1:0] prevAddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_image_selector #(
    .ADDR_W(AW), .DATA_W(DW), .PTR_ADDR(P_ADDR), .BASE_A(B_A), .BASE_B(B_B),
    .SEL_BIT(SBIT), .VALID_BIT(VBIT), .WDOG_CYCLES(WD)
  ) u_boot_image_selector (
    .clk(clk), .rstN(rstN), .start(startTask | startExtra),
    .memRd(memRd), .memAddr(memAddr), .memData(memData), .memReady(memReady),
    .bootDone(bootDone), .imageBase(imageBase), .launch(launch), .status(status)
  );

  function automatic logic [DW-1:0] lookup(input logic [AW-1:0] a);
    if (a == P_ADDR) return ptrWord;
    if (a == B_A) return hdrA;
    if (a == B_B) return hdrB;
    return '1;
  endfunction

  always @(negedge clk) begin
    // memory with random latency, one-cycle ready
    if (memReady) memReady = 1'b0;
    else if (memRd) begin
      if (lat == 0) begin
        memReady = 1'b1;
        memData  = lookup(memAddr);
        lat      = int'($urandom % 4);
      end else lat--;
    end
    // read protocol monitor (R2)
    if (rstN && prevRd && !prevReady && !(memRd && memAddr == prevAddr)) holdErr++;
    if (memRd && !prevRd && readIdx == 0) firstRdAddr = memAddr;
    if (memReady) begin
      if (readIdx == 1) firstHdrAddr = memAddr;
      readIdx++;
    end
    prevRd = memRd; prevReady = memReady; prevAddr = memAddr;
    if (status == 3'd1) sawSearch = 1;
    if (status == 3'd2) sawWait = 1;
    // boot-done responder
    bootDone   = 1'b0;
    startExtra = 1'b0;
    if (bdActive != 0) begin
      bdCnt++;
      if (bdCnt == bdDly) begin bootDone = 1'b1; bdActive = 0; end
    end
    if (launch) begin
      if (launches == 0) firstLaunchBase = imageBase;
      launches++;
      bdDly = (imageBase == B_A) ? dlyA : dlyB;
      bdCnt = 0;
      bdActive = (bdDly > 0) ? 1 : 0;
      if (startOnLaunch) startExtra = 1'b1;
    end
  end

  function automatic bit good(input logic [DW-1:0] h);
    return h[VBIT] == 1'b0;
  endfunction

  function automatic bit inTime(input int d);
    return d >= 1 && d <= WD;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic runSeq(input logic [DW-1:0] p, input logic [DW-1:0] a,
                        input logic [DW-1:0] b, input int da, input int db);
    bit firstB, okF, okS, fin;
    logic [2:0] expStat;
    int expLaunch;
    logic [AW-1:0] expFirstBase, fBase, sBase;
    ptrWord = p; hdrA = a; hdrB = b; dlyA = da; dlyB = db;
    firstB = (p[SBIT] == 1'b0);
    fBase = firstB ? B_B : B_A; sBase = firstB ? B_A : B_B;
    okF = good(firstB ? b : a) && inTime(firstB ? db : da);
    okS = good(firstB ? a : b) && inTime(firstB ? da : db);
    expLaunch = int'(good(firstB ? b : a));
    expFirstBase = good(firstB ? b : a) ? fBase : sBase;
    if (okF) expStat = firstB ? 3'd5 : 3'd4;
    else begin
      expLaunch += int'(good(firstB ? a : b));
      expStat = okS ? (firstB ? 3'd4 : 3'd5) : 3'd7;
    end
    launches = 0; readIdx = 0; holdErr = 0; sawSearch = 0; sawWait = 0; bdActive = 0;
    @(negedge clk); startTask = 1'b1;
    @(negedge clk); startTask = 1'b0;
    fin = 0;
    for (int i = 0; i < 400 && !fin; i++) begin
      @(negedge clk);
      if (status >= 3'd4) fin = 1;
    end
    repeat (3) @(negedge clk);
    check("R6/R7/R8 final status", 32'(status), 32'(expStat));
    check("R8 launch count", launches, expLaunch);
    check("R2 read hold", holdErr, 0);
    check("R2 pointer address", 32'(firstRdAddr), 32'(P_ADDR));
    check("R3/R4 first header address", 32'(firstHdrAddr), 32'(fBase));
    if (expLaunch > 0) check("R5 first launch base", 32'(firstLaunchBase), 32'(expFirstBase));
    check("R9 search status seen", 32'(sawSearch), 1);
    check("R9 wait status seen", 32'(sawWait), 32'(expLaunch > 0));
  endtask

  function automatic logic [DW-1:0] randHdr();
    int k = int'($urandom % 3);
    logic [DW-1:0] r = $urandom;
    if (k == 0) return '1;
    if (k == 1) return r & ~(32'd1 << VBIT);
    return r | (32'd1 << VBIT);
  endfunction

  function automatic int randDly();
    int k = int'($urandom % 4);
    if (k == 0) return 0;
    if (k == 1) return WD + 1 + int'($urandom % 3);
    return 1 + int'($urandom % WD);
  endfunction

  localparam logic [DW-1:0] GOOD = 32'h0000_0000;
  localparam logic [DW-1:0] BADV = 32'h0000_0020;
  localparam logic [DW-1:0] ONES = 32'hFFFF_FFFF;
  localparam logic [DW-1:0] PTR_B_ONLY = ~(32'd1 << SBIT);

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 reset status", 32'(status), 0);
    check("R1 reset launch", 32'(launch), 0);
    check("R1 reset read", 32'(memRd), 0);
    rstN = 1'b1;
    // R3: erased pointer picks A; clearing only the select bit picks B
    runSeq(ONES, GOOD, GOOD, 2, 2);
    runSeq(PTR_B_ONLY, GOOD, GOOD, 2, 2);
    // R3: other bits ignored
    runSeq(32'h0000_0008, GOOD, GOOD, 3, 3);
    // R4: erased and invalid headers fall over to the other image
    runSeq(ONES, ONES, GOOD, 1, 1);
    runSeq(ONES, BADV, GOOD, 1, 1);
    // R6 boundary: confirm at last accepted cycle
    runSeq(ONES, GOOD, GOOD, WD, 1);
    // R7 boundary: one cycle late falls back
    runSeq(ONES, GOOD, GOOD, WD + 1, 1);
    // R8: both fail
    runSeq(ONES, ONES, ONES, 1, 1);
    runSeq(PTR_B_ONLY, GOOD, GOOD, 0, 0);
    // R10: start while waiting has no effect; late bootDone ignored
    startOnLaunch = 1;
    runSeq(ONES, GOOD, GOOD, 3, 3);
    startOnLaunch = 0;
    runSeq(PTR_B_ONLY, GOOD, BADV, WD + 2, 0);
    for (int n = 0; n < 40; n++) runSeq($urandom, randHdr(), randHdr(), randDly(), randDly());
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule